// File: doc/BRIEF.md
# Programmable Interval Timer

A 32-bit down-counting interval timer. Software loads a period value and starts the timer through a small register write port. While running, the counter falls by one on every clock. When it has reached zero, the timer reloads the period and signals expiry. The gap between successive expiries is therefore the period plus one cycles.

Each expiry can raise two interrupt requests. One request is high priority and the other is low priority. Each request has its own unmask bit, and each feeds a sticky pending bit that software clears by writing ones. While the timer is stopped, software may preload the counter, so the first interval can differ from the period that follows. The current count is always visible on an output. Arbitration between the two requests and the driving of pins are left to the surrounding logic.

Register map. All writes need `we_i` high and take effect at the rising clock edge.

| Address | Register | Content |
|---|---|---|
| 0 | Control | bit 0 = run, bit 1 = high-priority unmask, bit 2 = low-priority unmask |
| 1 | Period | Period value |
| 2 | Counter | Counter preload |
| 3 | Pending clear | Write one to clear: bit 0 clears the high-priority pending bit, bit 1 clears the low-priority pending bit |

Top module: `interval_timer`

## Requirements
- R1: After reset, `count_o` is 0. `expiry_o`, `irq_hi_o`, `irq_lo_o` and `pend_o` are 0. The timer is stopped and both requests are masked.
- R2: While running with a nonzero count, `count_o` falls by exactly one on each clock.
- R3: On an edge where the timer is running and the count is 0, the count reloads from the period register. `expiry_o` is then high for the following cycle.
- R4: With a constant period P, successive `expiry_o` pulses are exactly P+1 cycles apart.
- R5: Control bit 0 starts the timer when set and stops it when cleared. While stopped, the count holds and `expiry_o` stays low.
- R6: A write to address 2 while stopped loads the counter on that edge. The same write while running is ignored.
- R7: `irq_hi_o` pulses together with `expiry_o` only when control bit 1 is set. `irq_lo_o` does the same only when control bit 2 is set. A masked request stays low.
- R8: `pend_o[0]` is set by each `irq_hi_o` pulse and `pend_o[1]` by each `irq_lo_o` pulse. Writing a one to the matching bit at address 3 clears it. A set in the same cycle takes priority over the clear.
- R9: A write to the period register does not alter the running count. It is used from the next reload onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write enable |
| addr_i | input | 2 | Register address |
| wdata_i | input | 32 | Write data |
| count_o | output | 32 | Current counter value |
| expiry_o | output | 1 | One-cycle pulse per expiry |
| irq_hi_o | output | 1 | High-priority interrupt request pulse |
| irq_lo_o | output | 1 | Low-priority interrupt request pulse |
| pend_o | output | 2 | Sticky pending bits, high priority at bit 0 |

## Verification
The assertions check the per-cycle rules on every clock. These cover the one-step decrement while running, the hold and silence while stopped, and the preload while stopped. They also cover the expiry that follows a zero count, and the coupling of each request to expiry and to its pending bit. Only the bench scenarios can show the properties that span many cycles. These are the P+1 spacing of expiries, a counter write ignored while running, and a period change that waits for the next reload. The scenarios also show masking and the write-one-to-clear of pending bits, and the zero-period case where expiry repeats every cycle.

// File: rtl/interval_timer_pkg.sv
package interval_timer_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned NUM_REQ = 2;
  localparam int unsigned REQ_HI = 0;
  localparam int unsigned REQ_LO = 1;
  localparam int unsigned CTRL_RUN = 0;
  localparam int unsigned CTRL_UNMASK_LSB = 1;

  typedef enum logic [ADDR_W-1:0] {
    SEL_CTRL     = 2'd0,
    SEL_PERIOD   = 2'd1,
    SEL_COUNT    = 2'd2,
    SEL_PEND_CLR = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import interval_timer_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [WIDTH-1:0]   wdata_i,
  output logic               run_o,
  output logic [NUM_REQ-1:0] unmask_o,
  output logic [WIDTH-1:0]   period_o,
  output logic               cnt_load_o,
  output logic [NUM_REQ-1:0] pend_clr_o
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o    <= 1'b0;
      unmask_o <= '0;
      period_o <= '0;
    end else if (we_i) begin
      if (sel == SEL_CTRL) begin
        run_o    <= wdata_i[CTRL_RUN];
        unmask_o <= wdata_i[CTRL_UNMASK_LSB +: NUM_REQ];
      end
      if (sel == SEL_PERIOD) period_o <= wdata_i;
    end
  end

  assign cnt_load_o = we_i && (sel == SEL_COUNT);
  assign pend_clr_o = (we_i && (sel == SEL_PEND_CLR)) ? wdata_i[NUM_REQ-1:0] : '0;
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_val_i,
  input  logic [WIDTH-1:0] period_i,
  output logic [WIDTH-1:0] count_o,
  output logic             tick_o,
  output logic             expiry_o
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  assign tick_o = run_i && (count_o == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_o  <= '0;
      expiry_o <= 1'b0;
    end else begin
      expiry_o <= tick_o;
      if (run_i) count_o <= tick_o ? period_i : count_o - ONE;
      else if (load_i) count_o <= load_val_i;  // preload only while stopped
    end
  end
endmodule

// File: rtl/tmr_req.sv
module tmr_req #(
  parameter int unsigned NUM = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           tick_i,
  input  logic [NUM-1:0] unmask_i,
  input  logic [NUM-1:0] clr_i,
  output logic [NUM-1:0] req_o,
  output logic [NUM-1:0] pend_o
);
  for (genvar k = 0; k < NUM; k++) begin : g_req
    logic fire;
    assign fire = tick_i && unmask_i[k];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        req_o[k]  <= 1'b0;
        pend_o[k] <= 1'b0;
      end else begin
        req_o[k]  <= fire;
        pend_o[k] <= fire || (pend_o[k] && !clr_i[k]);  // set wins
      end
    end
  end
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import interval_timer_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [WIDTH-1:0]   wdata_i,
  output logic [WIDTH-1:0]   count_o,
  output logic               expiry_o,
  output logic               irq_hi_o,
  output logic               irq_lo_o,
  output logic [NUM_REQ-1:0] pend_o
);
  logic               run_w;
  logic [NUM_REQ-1:0] unmask_w;
  logic [WIDTH-1:0]   period_w;
  logic               cnt_load_w;
  logic [NUM_REQ-1:0] clr_w;
  logic               tick_w;
  logic [NUM_REQ-1:0] req_w;

  tmr_regs #(.WIDTH(WIDTH)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .run_o      (run_w),
    .unmask_o   (unmask_w),
    .period_o   (period_w),
    .cnt_load_o (cnt_load_w),
    .pend_clr_o (clr_w)
  );

  tmr_counter #(.WIDTH(WIDTH)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_w),
    .load_i     (cnt_load_w),
    .load_val_i (wdata_i),
    .period_i   (period_w),
    .count_o    (count_o),
    .tick_o     (tick_w),
    .expiry_o   (expiry_o)
  );

  tmr_req #(.NUM(NUM_REQ)) u_req (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_w),
    .unmask_i (unmask_w),
    .clr_i    (clr_w),
    .req_o    (req_w),
    .pend_o   (pend_o)
  );

  assign irq_hi_o = req_w[REQ_HI];
  assign irq_lo_o = req_w[REQ_LO];
endmodule

// File: rtl/interval_timer_chk.sv
module interval_timer_chk #(
  parameter int unsigned WIDTH = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             we_i,
  input logic [1:0]       addr_i,
  input logic [WIDTH-1:0] wdata_i,
  input logic [WIDTH-1:0] count_o,
  input logic             expiry_o,
  input logic             irq_hi_o,
  input logic             irq_lo_o,
  input logic [1:0]       pend_o,
  input logic             run
);
  assert_count_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && count_o != '0) |=> count_o == $past(count_o) - WIDTH'(1));

  assert_zero_expires_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && count_o == '0) |=> expiry_o);

  assert_hold_stopped_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !(we_i && addr_i == 2'd2)) |=> $stable(count_o));

  assert_quiet_stopped_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> !expiry_o);

  assert_preload_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && we_i && addr_i == 2'd2) |=> count_o == $past(wdata_i));

  assert_hi_with_expiry_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_hi_o |-> expiry_o);

  assert_lo_with_expiry_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_lo_o |-> expiry_o);

  assert_hi_pending_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_hi_o |-> pend_o[0]);

  assert_lo_pending_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_lo_o |-> pend_o[1]);
endmodule

bind interval_timer interval_timer_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .count_o  (count_o),
  .expiry_o (expiry_o),
  .irq_hi_o (irq_hi_o),
  .irq_lo_o (irq_lo_o),
  .pend_o   (pend_o),
  .run      (run_w)
);

// File: tb/interval_timer_tb_top.sv
`timescale 1ns/1ps
module interval_timer_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [1:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] count_o;
  logic        expiry_o, irq_hi_o, irq_lo_o;
  logic [1:0]  pend_o;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  interval_timer dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .count_o(count_o), .expiry_o(expiry_o), .irq_hi_o(irq_hi_o), .irq_lo_o(irq_lo_o),
    .pend_o(pend_o)
  );

  // behavioural reference
  bit          m_run, m_mhi, m_mlo, m_exp, m_ihi, m_ilo;
  bit [1:0]    m_pend;
  logic [31:0] m_cnt, m_period;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_run = 0; m_mhi = 0; m_mlo = 0; m_exp = 0; m_ihi = 0; m_ilo = 0;
      m_pend = 0; m_cnt = 0; m_period = 0;
    end else begin
      bit zero_hit;
      zero_hit = m_run && (m_cnt == 0);
      m_exp = zero_hit;
      m_ihi = zero_hit && m_mhi;
      m_ilo = zero_hit && m_mlo;
      if (m_run) m_cnt = zero_hit ? m_period : m_cnt - 1;
      else if (we_i && addr_i == 2) m_cnt = wdata_i;
      if (we_i && addr_i == 3) m_pend = m_pend & ~wdata_i[1:0];
      m_pend = m_pend | {m_ilo, m_ihi};
      if (we_i && addr_i == 0) begin
        m_run = wdata_i[0]; m_mhi = wdata_i[1]; m_mlo = wdata_i[2];
      end
      if (we_i && addr_i == 1) m_period = wdata_i;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      cycles++;
      check(count_o == m_cnt, "R2 count", count_o, m_cnt);
      check(expiry_o == m_exp, "R3 expiry", expiry_o, m_exp);
      check(irq_hi_o == m_ihi && irq_lo_o == m_ilo, "R7 requests",
            {irq_lo_o, irq_hi_o}, {m_ilo, m_ihi});
      check(pend_o == m_pend, "R8 pending", pend_o, m_pend);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk_i); #1;
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i); #1;
    we_i = 1'b0;
  endtask

  task automatic wait_expiry();
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk_i);
      if (expiry_o) break;
    end
  endtask

  task automatic measure_gap(input int expected, input string req);
    int n;
    wait_expiry();
    n = 0;
    do begin
      @(negedge clk_i);
      n++;
    end while (!expiry_o && n < 1000);
    check(n == expected, req, n, expected);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    check(count_o == 0 && !expiry_o && !irq_hi_o && !irq_lo_o && pend_o == 0,
          "R1 reset", count_o, 0);

    // R4 spacing with period 5, both requests unmasked
    wr(2'd1, 32'd5);
    wr(2'd0, 32'h7);
    measure_gap(6, "R4 gap period 5");
    check(pend_o == 2'b11, "R8 both pending", pend_o, 3);
    wr(2'd3, 32'h1);
    @(negedge clk_i);
    check(pend_o[0] == 1'b0 || m_pend[0], "R8 clear hi", pend_o, m_pend);

    // R5 stop: count holds
    wr(2'd0, 32'h6);
    begin
      logic [31:0] held;
      held = count_o;
      repeat (5) @(negedge clk_i);
      check(count_o == held && !expiry_o, "R5 hold while stopped", count_o, held);
    end

    // R6 preload while stopped, masks off
    wr(2'd3, 32'h3);
    wr(2'd2, 32'd2);
    check(count_o == 32'd2, "R6 preload", count_o, 2);
    wr(2'd0, 32'h1);
    wait_expiry();
    check(!irq_hi_o && !irq_lo_o, "R7 masked requests", {irq_lo_o, irq_hi_o}, 0);
    check(pend_o == 0, "R7 masked no pending", pend_o, 0);

    // R6 write ignored while running
    wr(2'd2, 32'd100);
    check(count_o != 32'd100, "R6 ignored while running", count_o, m_cnt);

    // R9 period change waits for reload; only low request unmasked
    wr(2'd0, 32'h5);
    wait_expiry();
    @(negedge clk_i);
    wr(2'd1, 32'd3);
    check(count_o == m_cnt && count_o != 32'd3, "R9 count undisturbed", count_o, m_cnt);
    measure_gap(4, "R9 new period at reload");
    check(pend_o == 2'b10, "R7 low only", pend_o, 2);

    // R4 zero period: expiry every cycle
    wr(2'd1, 32'd0);
    wait_expiry();
    measure_gap(1, "R4 gap period 0");
    repeat (4) @(negedge clk_i);
    check(expiry_o == 1'b1, "R3 continuous expiry", expiry_o, 1);

    wr(2'd0, 32'h0);
    repeat (3) @(negedge clk_i);
    check(!expiry_o, "R5 stop", expiry_o, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule